// File: doc/BRIEF.md
# Ordered Store Buffer

The block sits between a processor's load/store port and the memory ports. Stores are taken into an eight-slot buffer and written to memory later. Loads do not wait for those stores. A load whose address matches a buffered store takes its data from the buffer. Every other load goes straight to the memory read port, even while older stores are still waiting.

A mode input selects one of two drain policies.

- **Strict mode:** stores leave in the order they arrived.
- **Relaxed mode:** the buffer writes the oldest store that may legally go now. A store is skipped only when its memory bank is reported busy, and the stores behind it may then go first.

In both modes three rules hold:

- A store barrier splits the buffered stores into epochs. No store may leave while a store from an earlier epoch is still buffered.
- Stores to one address keep their order.
- Once a write has been offered to memory, it stays offered unchanged until memory takes it.

Top module: `stbuf_order`

## Requirements
- R1: After reset the buffer is empty: `st_ready_o` is 1, `mem_wr_valid_o` is 0, and every load misses.
- R2: A store is accepted when `st_valid_i` and `st_ready_o` are both high. `st_ready_o` is 1 exactly while fewer than 8 stores are held, so it is 0 when the buffer is full.
- R3: With `pso_mode_i` = 0, the write offered to memory is always the oldest buffered store. Writes leave in acceptance order, and `mem_bank_busy_i` has no effect.
- R4: With `pso_mode_i` = 1, a fresh write offer is the oldest buffered store that meets three conditions: its epoch equals the oldest store's epoch, no older buffered store has its address, and its bank is not flagged. The bank is address bits [3:2], and a bank is flagged when `mem_bank_busy_i[bank]` is 1. When no store qualifies, `mem_wr_valid_o` is 0.
- R5: A store accepted after a barrier request (`fence_i` = 1) never reaches memory while any store accepted before that request is still buffered. A store accepted in the same cycle as the barrier counts as after it.
- R6: No store is written to memory while an older store to the same address is still buffered.
- R7: A load (`ld_valid_i` = 1) that matches buffered stores behaves as follows. `ld_hit_o` is 1 and `ld_data_o` carries the data of the youngest match. `mem_rd_valid_o` is 0 and `ld_ready_o` is 1, all in the same cycle.
- R8: A load that matches no buffered store behaves as follows. `mem_rd_valid_o` is 1 with `mem_rd_addr_o` equal to the load address, `ld_hit_o` is 0, and `ld_ready_o` follows `mem_rd_ready_i`. This holds regardless of how many stores are pending.
- R9: While `mem_wr_valid_o` is 1 and `mem_wr_ready_i` is 0, the next cycle offers the same address and data again. The entry leaves the buffer in the cycle its write is accepted.
- R10: A load in the same cycle as a store being accepted does not see that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pso_mode_i | input | 1 | 0 = in-order drain, 1 = relaxed drain |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | 32 | Store address |
| st_data_i | input | 32 | Store data |
| st_ready_o | output | 1 | Store can be accepted |
| fence_i | input | 1 | Store barrier request |
| ld_valid_i | input | 1 | Load request |
| ld_addr_i | input | 32 | Load address |
| ld_ready_o | output | 1 | Load accepted this cycle |
| ld_hit_o | output | 1 | Load served from the buffer |
| ld_data_o | output | 32 | Forwarded load data |
| mem_rd_valid_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | 32 | Memory read address |
| mem_rd_ready_i | input | 1 | Memory read accepted |
| mem_wr_valid_o | output | 1 | Memory write offered |
| mem_wr_addr_o | output | 32 | Memory write address |
| mem_wr_data_o | output | 32 | Memory write data |
| mem_wr_ready_i | input | 1 | Memory write accepted |
| mem_bank_busy_i | input | 4 | Per-bank busy hint for the relaxed drain |

## Verification
The in-order assertion assumes that `pso_mode_i` changes only while the buffer is empty. A write offered in relaxed mode may still be waiting when the mode returns to in-order, and it need not be the oldest. The stimulus therefore drains the buffer completely before each mode switch. The assertions also assume that the store side respects `st_ready_o`, which the stimulus does by driving stores blindly and letting refusals happen. Addresses are drawn from eight words that span all four banks. This makes forwarding hits, same-address chains and bank skips frequent.

// File: rtl/stbuf_pkg.sv
// Package: shared constants and the buffered-store record.
// Assumes: the epoch width exceeds log2 of the buffer depth plus one.
package stbuf_pkg;
    localparam int SB_AW  = 32;
    localparam int SB_DW  = 32;
    localparam int SB_EPW = 8;

    typedef struct packed {
        logic              vld;
        logic [SB_AW-1:0]  addr;
        logic [SB_DW-1:0]  data;
        logic [SB_EPW-1:0] ep;
    } sb_entry_t;
endpackage

// File: rtl/stbuf_queue.sv
// Module: age-ordered store storage. Slot 0 is the oldest store.
// Removing a store from any slot shifts the younger slots down by one.
// A new store lands behind the last valid slot.
// Assumes: push only when count < DEPTH; pop_idx_i names a valid slot.
module stbuf_queue
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pso_i,
    input  logic                  push_i,
    input  sb_entry_t             push_entry_i,
    input  logic                  pop_i,
    input  logic [IW-1:0]         pop_idx_i,
    output sb_entry_t [DEPTH-1:0] q_o,
    output logic [CW-1:0]         cnt_o
);
    sb_entry_t [DEPTH-1:0] q_q, q_d;
    logic [CW-1:0]         cnt_q, cnt_mid, cnt_d;

    // Next-state contents: close the gap left by a pop, then append the push.
    always_comb begin
        q_d     = q_q;
        cnt_mid = cnt_q - CW'(pop_i);
        if (pop_i) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
                if (k >= int'(pop_idx_i)) q_d[k] = q_q[k + 1];
            end
            q_d[DEPTH-1] = '0;
        end
        if (push_i) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (CW'(k) == cnt_mid) begin
                    q_d[k]     = push_entry_i;
                    q_d[k].vld = 1'b1;
                end
            end
        end
        cnt_d = cnt_mid + CW'(push_i);
    end

    // State register for the slots and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q   <= '0;
            cnt_q <= '0;
        end else begin
            q_q   <= q_d;
            cnt_q <= cnt_d;
        end
    end

    assign q_o   = q_q;
    assign cnt_o = cnt_q;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    assert_inorder_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !pso_i) |-> (pop_idx_i == '0));

    assert_epoch_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (q_q[pop_idx_i].ep == q_q[0].ep));

    assert_pop_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> q_q[pop_idx_i].vld);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ord
        assert_same_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_i && (IW'(i) < pop_idx_i) && q_q[i].vld)
                |-> (q_q[i].addr != q_q[pop_idx_i].addr));
    end
endmodule

// File: rtl/stbuf_drain_pick.sv
// Module: chooses the slot to offer to memory.
// In-order mode offers slot 0. Relaxed mode offers the oldest slot that
// shares slot 0's epoch, has no older store to its address, and sits in a
// bank not flagged busy.
// Assumes: the slots are age ordered with no holes.
module stbuf_drain_pick
    import stbuf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int BANKS    = 4,
    parameter int BANK_LSB = 2,
    parameter int IW       = $clog2(DEPTH),
    parameter int BKW      = $clog2(BANKS)
) (
    input  sb_entry_t [DEPTH-1:0] q_i,
    input  logic                  pso_i,
    input  logic [BANKS-1:0]      busy_i,
    output logic                  pick_vld_o,
    output logic [IW-1:0]         pick_idx_o
);
    logic [DEPTH-1:0] elig;

    for (genvar j = 0; j < DEPTH; j++) begin : g_el
        logic older_same;
        // Look for an older buffered store to the same address.
        always_comb begin
            older_same = 1'b0;
            for (int i = 0; i < j; i++) begin
                if (q_i[i].vld && (q_i[i].addr == q_i[j].addr)) older_same = 1'b1;
            end
        end
        assign elig[j] = q_i[j].vld && (q_i[j].ep == q_i[0].ep) && !older_same
                         && !busy_i[q_i[j].addr[BANK_LSB +: BKW]];
    end

    // Oldest eligible slot wins in relaxed mode; head only in in-order mode.
    always_comb begin
        pick_vld_o = 1'b0;
        pick_idx_o = '0;
        if (!pso_i) begin
            pick_vld_o = q_i[0].vld;
        end else begin
            for (int j = DEPTH - 1; j >= 0; j--) begin
                if (elig[j]) begin
                    pick_vld_o = 1'b1;
                    pick_idx_o = IW'(j);
                end
            end
        end
    end
endmodule

// File: rtl/stbuf_fwd.sv
// Module: load-to-store forwarding. It matches a load address against
// every valid slot and returns the youngest match.
// Assumes: higher slot index means younger store.
module stbuf_fwd
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  sb_entry_t [DEPTH-1:0] q_i,
    input  logic [SB_AW-1:0]      addr_i,
    output logic                  hit_o,
    output logic [SB_DW-1:0]      data_o
);
    // Scan oldest to youngest so that the last match found is the youngest.
    always_comb begin
        hit_o  = 1'b0;
        data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (q_i[k].vld && (q_i[k].addr == addr_i)) begin
                hit_o  = 1'b1;
                data_o = q_i[k].data;
            end
        end
    end
endmodule

// File: rtl/stbuf_order.sv
// Module: store buffer top. It accepts stores, serves matching loads from
// the buffer, passes other loads to memory, and drains stores under the
// selected ordering mode. Barriers advance the store epoch, and runs of
// barriers with no store between them fold into a single step.
// Assumes: pso_mode_i changes only while the buffer is empty.
module stbuf_order
    import stbuf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int BANKS    = 4,
    parameter int BANK_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pso_mode_i,
    input  logic             st_valid_i,
    input  logic [31:0]      st_addr_i,
    input  logic [31:0]      st_data_i,
    output logic             st_ready_o,
    input  logic             fence_i,
    input  logic             ld_valid_i,
    input  logic [31:0]      ld_addr_i,
    output logic             ld_ready_o,
    output logic             ld_hit_o,
    output logic [31:0]      ld_data_o,
    output logic             mem_rd_valid_o,
    output logic [31:0]      mem_rd_addr_o,
    input  logic             mem_rd_ready_i,
    output logic             mem_wr_valid_o,
    output logic [31:0]      mem_wr_addr_o,
    output logic [31:0]      mem_wr_data_o,
    input  logic             mem_wr_ready_i,
    input  logic [BANKS-1:0] mem_bank_busy_i
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    sb_entry_t [DEPTH-1:0] q;
    logic [CW-1:0]         cnt;
    logic                  push, pop;
    sb_entry_t             push_entry;
    logic [SB_EPW-1:0]     cur_ep_q, new_ep;
    logic                  bar_pend_q;
    logic                  pick_vld, held_q, fwd_hit;
    logic [IW-1:0]         pick_idx, held_idx_q, sel_idx;
    logic [SB_DW-1:0]      fwd_data;

    assign st_ready_o = (cnt < CW'(DEPTH));
    assign push       = st_valid_i && st_ready_o;
    assign new_ep     = (bar_pend_q || fence_i) ? cur_ep_q + SB_EPW'(1) : cur_ep_q;

    // Build the record for an incoming store.
    always_comb begin
        push_entry.vld  = 1'b1;
        push_entry.addr = st_addr_i;
        push_entry.data = st_data_i;
        push_entry.ep   = new_ep;
    end

    // Epoch tracking: a pending barrier takes effect at the next store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ep_q   <= '0;
            bar_pend_q <= 1'b0;
        end else if (push) begin
            cur_ep_q   <= new_ep;
            bar_pend_q <= 1'b0;
        end else if (fence_i) begin
            bar_pend_q <= 1'b1;
        end
    end

    stbuf_queue #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) queue_i (
        .clk(clk), .rst_n(rst_n), .pso_i(pso_mode_i),
        .push_i(push), .push_entry_i(push_entry),
        .pop_i(pop), .pop_idx_i(sel_idx),
        .q_o(q), .cnt_o(cnt)
    );

    stbuf_drain_pick #(.DEPTH(DEPTH), .BANKS(BANKS), .BANK_LSB(BANK_LSB), .IW(IW)) pick_i (
        .q_i(q), .pso_i(pso_mode_i), .busy_i(mem_bank_busy_i),
        .pick_vld_o(pick_vld), .pick_idx_o(pick_idx)
    );

    stbuf_fwd #(.DEPTH(DEPTH)) fwd_i (
        .q_i(q), .addr_i(ld_addr_i), .hit_o(fwd_hit), .data_o(fwd_data)
    );

    // A refused write offer stays locked on its slot until memory takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= 1'b0;
            held_idx_q <= '0;
        end else begin
            held_q <= mem_wr_valid_o && !mem_wr_ready_i;
            if (mem_wr_valid_o) held_idx_q <= sel_idx;
        end
    end

    assign sel_idx        = held_q ? held_idx_q : pick_idx;
    assign mem_wr_valid_o = held_q || pick_vld;
    assign mem_wr_addr_o  = q[sel_idx].addr;
    assign mem_wr_data_o  = q[sel_idx].data;
    assign pop            = mem_wr_valid_o && mem_wr_ready_i;

    assign ld_hit_o       = ld_valid_i && fwd_hit;
    assign ld_data_o      = fwd_data;
    assign mem_rd_valid_o = ld_valid_i && !fwd_hit;
    assign mem_rd_addr_o  = ld_addr_i;
    assign ld_ready_o     = fwd_hit || mem_rd_ready_i;

    assert_hold_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid_o && !mem_wr_ready_i)
            |=> (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));
endmodule

// File: tb/stbuf_order_tb_top.sv
`timescale 1ns/1ps
module stbuf_order_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pso_mode_i = 1'b0;
    logic        st_valid_i = 1'b0, fence_i = 1'b0, ld_valid_i = 1'b0;
    logic [31:0] st_addr_i = '0, st_data_i = '0, ld_addr_i = '0;
    logic        mem_rd_ready_i = 1'b0, mem_wr_ready_i = 1'b0;
    logic [3:0]  mem_bank_busy_i = '0;
    logic        st_ready_o, ld_ready_o, ld_hit_o, mem_rd_valid_o, mem_wr_valid_o;
    logic [31:0] ld_data_o, mem_rd_addr_o, mem_wr_addr_o, mem_wr_data_o;

    always #4 clk = ~clk;   // 125 MHz

    stbuf_order dut_i (
        .clk(clk), .rst_n(rst_n), .pso_mode_i(pso_mode_i),
        .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_data_i(st_data_i),
        .st_ready_o(st_ready_o), .fence_i(fence_i),
        .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i), .ld_ready_o(ld_ready_o),
        .ld_hit_o(ld_hit_o), .ld_data_o(ld_data_o),
        .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_rd_ready_i(mem_rd_ready_i),
        .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_addr_o(mem_wr_addr_o),
        .mem_wr_data_o(mem_wr_data_o), .mem_wr_ready_i(mem_wr_ready_i),
        .mem_bank_busy_i(mem_bank_busy_i)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    // Bench model of the buffered stores, oldest first.
    int          m_n = 0;
    logic [31:0] m_addr [0:15];
    logic [31:0] m_data [0:15];
    int          m_ep   [0:15];
    int          ep_b = 0;
    logic [31:0] data_ctr = 32'h0000_1000;
    bit          held_b = 0;
    logic [31:0] h_addr, h_data;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int bank_of(input logic [31:0] a);
        return int'((a >> 2) & 32'd3);
    endfunction

    // Expected fresh offer from the requirements (R3 and R4); -1 means none.
    function automatic int exp_pick(input bit pso, input logic [3:0] busy);
        if (m_n == 0) return -1;
        if (!pso) return 0;
        for (int j = 0; j < m_n; j++) begin
            bit ok;
            ok = (m_ep[j] == m_ep[0]) && !busy[bank_of(m_addr[j])];
            for (int i = 0; i < j; i++) if (m_addr[i] == m_addr[j]) ok = 0;
            if (ok) return j;
        end
        return -1;
    endfunction

    // One cycle: drive at the falling edge, check just after, then update the model.
    task automatic step(input bit sv, input logic [31:0] sa, input bit fc,
                        input bit lv, input logic [31:0] la, input bit wr_rdy,
                        input bit rd_rdy, input logic [3:0] busy);
        bit exp_rdy, st_fire, eh, fire;
        logic [31:0] ed;
        int p, fj;
        @(negedge clk);
        st_valid_i = sv; st_addr_i = sa; st_data_i = data_ctr; fence_i = fc;
        ld_valid_i = lv; ld_addr_i = la; mem_wr_ready_i = wr_rdy;
        mem_rd_ready_i = rd_rdy; mem_bank_busy_i = busy;
        #2;
        exp_rdy = (m_n < 8);
        chk(st_ready_o == exp_rdy, "R2", {31'd0, st_ready_o}, {31'd0, exp_rdy});
        st_fire = sv && exp_rdy;
        // Write side: a held offer is repeated unchanged, a fresh one follows R3/R4.
        if (held_b) begin
            chk(mem_wr_valid_o && mem_wr_addr_o == h_addr && mem_wr_data_o == h_data,
                "R9", mem_wr_data_o, h_data);
        end else begin
            p = exp_pick(pso_mode_i, busy);
            if (p < 0) chk(!mem_wr_valid_o, pso_mode_i ? "R4" : "R3", {31'd0, mem_wr_valid_o}, 32'd0);
            else chk(mem_wr_valid_o && mem_wr_addr_o == m_addr[p] && mem_wr_data_o == m_data[p],
                     pso_mode_i ? "R4" : "R3", mem_wr_data_o, m_data[p]);
        end
        // Load side: youngest match from the model state before this cycle's store (R10).
        if (lv) begin
            eh = 0; ed = '0;
            for (int k = 0; k < m_n; k++) if (m_addr[k] == la) begin eh = 1; ed = m_data[k]; end
            chk(ld_hit_o == eh && (!eh || ld_data_o == ed),
                (st_fire && sa == la) ? "R10" : "R7", ld_data_o, ed);
            chk(mem_rd_valid_o == !eh && (eh || mem_rd_addr_o == la) && ld_ready_o == (eh || rd_rdy),
                "R8", mem_rd_addr_o, la);
        end
        fire = mem_wr_valid_o && wr_rdy;
        held_b = mem_wr_valid_o && !wr_rdy;
        h_addr = mem_wr_addr_o; h_data = mem_wr_data_o;
        if (fire) begin
            fj = -1;
            for (int k = 0; k < m_n; k++)
                if (m_data[k] == mem_wr_data_o && m_addr[k] == mem_wr_addr_o) fj = k;
            chk(fj >= 0, "R9", mem_wr_data_o, 32'd0);
            if (fj >= 0) begin
                chk(m_ep[fj] == m_ep[0], "R5", m_ep[fj], m_ep[0]);
                for (int i = 0; i < fj; i++)
                    if (m_addr[i] == m_addr[fj]) chk(0, "R6", m_data[fj], m_data[i]);
                for (int k = fj; k < m_n - 1; k++) begin
                    m_addr[k] = m_addr[k+1]; m_data[k] = m_data[k+1]; m_ep[k] = m_ep[k+1];
                end
                m_n--;
            end
        end
        if (fc) ep_b++;
        if (st_fire) begin
            m_addr[m_n] = sa; m_data[m_n] = data_ctr; m_ep[m_n] = ep_b; m_n++;
            data_ctr++;
        end
    endtask

    task automatic drain();
        for (int c = 0; c < 40 && m_n > 0; c++) step(0, 0, 0, 0, 0, 1, 1, 4'h0);
        chk(m_n == 0, "R3", m_n, 0);
    endtask

    function automatic logic [31:0] raddr();
        return ($urandom % 8) * 4;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        chk(st_ready_o == 1'b1 && mem_wr_valid_o == 1'b0, "R1", {31'd0, mem_wr_valid_o}, 32'd0);
        step(0, 0, 0, 1, 32'h10, 0, 1, 4'h0);   // R1: empty buffer, load misses

        // R2: in-order mode, memory stalled, ten store attempts; the last two are refused.
        for (int k = 0; k < 10; k++) step(1, k * 4, 0, 1, 32'h8, 0, 1, 4'hF);
        drain();

        // R4: relaxed mode, bank 0 busy, so the store to bank 1 overtakes.
        pso_mode_i = 1'b1;
        step(1, 32'h0, 0, 0, 0, 0, 0, 4'h1);
        step(1, 32'h4, 0, 0, 0, 0, 0, 4'h1);
        step(0, 0, 0, 0, 0, 1, 0, 4'h1);
        drain();
        // R5: a barrier between the stores blocks the younger one while bank 0 is busy.
        step(1, 32'h0, 0, 0, 0, 0, 0, 4'h1);
        step(1, 32'h4, 1, 0, 0, 0, 0, 4'h1);
        step(0, 0, 0, 0, 0, 1, 0, 4'h1);
        step(0, 0, 0, 0, 0, 1, 0, 4'h1);
        drain();
        // R10: a store and a load to one address in the same cycle.
        step(1, 32'h18, 0, 1, 32'h18, 0, 0, 4'h0);
        step(0, 0, 0, 1, 32'h18, 0, 0, 4'h0);  // R7: now it hits
        drain();
        // R6: same-address chain with a younger store to another bank.
        step(1, 32'h0, 0, 0, 0, 0, 0, 4'h0);
        step(1, 32'h0, 0, 0, 0, 0, 0, 4'h0);
        step(1, 32'h4, 0, 1, 32'h0, 0, 0, 4'h0);
        drain();

        // Random in-order traffic.
        pso_mode_i = 1'b0;
        for (int c = 0; c < 3000; c++)
            step(($urandom % 4) != 0, raddr(), ($urandom % 8) == 0, $urandom % 2, raddr(),
                 ($urandom % 2) == 0, $urandom % 2, 4'($urandom));
        drain();
        // Random relaxed traffic.
        pso_mode_i = 1'b1;
        for (int c = 0; c < 4000; c++)
            step(($urandom % 4) != 0, raddr(), ($urandom % 8) == 0, $urandom % 2, raddr(),
                 ($urandom % 2) == 0, $urandom % 2, 4'($urandom));
        drain();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule